// File: doc/BRIEF.md
# Bidirectional Shift Register with Serial Fill

An 8-bit clocked register that serves as the shift path of an ALU and as the route by which bus data reaches the accumulator. A 2-bit mode input selects one of four actions at each rising clock edge: keep the stored value, shift it one place toward the MSB, shift it one place toward the LSB, or capture the parallel data input. A separate serial carry input supplies the bit that enters the position a shift leaves empty. Both shift directions use it.

A second output holds the bit that the most recent shift pushed out of the register, so that the flag logic can take a carry from it. An active-low asynchronous clear forces the register and the shift-out bit to zero at any time and overrides every mode. A parallel capture takes effect only at a clock edge, so bus data is ready for the accumulator one cycle after the load is requested.

Top module: `bidir_shift_reg`

## Requirements
- R1: While rst_ni is low, q_o and shout_o are 0. They go to 0 as soon as rst_ni falls, mid-cycle and without waiting for a clock edge, and they stay 0 across clock edges for as long as rst_ni is low, whatever the mode.
- R2: With mode_i = 2'b00 (hold), q_o keeps its value across a rising edge.
- R3: With mode_i = 2'b01 (left shift), a rising edge loads q_o with {q_o[6:0], cin_i}. For example 0x40 with cin_i = 0 becomes 0x80.
- R4: With mode_i = 2'b10 (right shift), a rising edge loads q_o with {cin_i, q_o[7:1]}. For example 0x09 with cin_i = 0 becomes 0x04.
- R5: With mode_i = 2'b11 (load), q_o takes data_i at the rising edge and not before. A change of data_i within the cycle does not reach q_o until that edge.
- R6: On a left shift, shout_o takes the old q_o[7] at the same edge. On a right shift it takes the old q_o[0]. For example, a right shift of 0x09 gives shout_o = 1.
- R7: In hold and load modes, shout_o keeps its previous value.
- R8: cin_i = 1 places a 1 in bit 0 on a left shift and in bit 7 on a right shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous clear, active low |
| mode_i | input | 2 | 00 hold, 01 shift left, 10 shift right, 11 parallel load |
| cin_i | input | 1 | Serial fill bit for the vacated position |
| data_i | input | 8 | Parallel load data |
| q_o | output | 8 | Register contents |
| shout_o | output | 1 | Bit most recently shifted out |

## Verification
All state in this block is visible directly on q_o and shout_o. A wrong next-state value therefore appears one sample after the edge that caused it. A wrong shift-out bit appears on the same edge as the shift that produced it. A stale shout_o that should have been held shows up as soon as a hold or load follows a shift. A clear that waits for a clock shows up inside the cycle in which rst_ni fell, because the bench samples before the next edge.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHL  = 2'b01,
    MODE_SHR  = 2'b10,
    MODE_LOAD = 2'b11
  } shreg_mode_e;
endpackage

// File: rtl/shreg_next.sv
module shreg_next
  import shreg_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  shreg_mode_e      mode_i,
  input  logic             cin_i,
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             shout_i,
  output logic [WIDTH-1:0] nxt_o,
  output logic             shout_o
);
  localparam int unsigned MSB = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_lo; // source on left shift
    logic from_hi; // source on right shift
    if (i == 0) begin : g_lo_end
      assign from_lo = cin_i;
    end else begin : g_lo_mid
      assign from_lo = cur_i[i-1];
    end
    if (i == MSB) begin : g_hi_end
      assign from_hi = cin_i;
    end else begin : g_hi_mid
      assign from_hi = cur_i[i+1];
    end
    always_comb begin
      unique case (mode_i)
        MODE_SHL:  nxt_o[i] = from_lo;
        MODE_SHR:  nxt_o[i] = from_hi;
        MODE_LOAD: nxt_o[i] = data_i[i];
        default:   nxt_o[i] = cur_i[i];
      endcase
    end
  end

  always_comb begin
    unique case (mode_i)
      MODE_SHL: shout_o = cur_i[MSB];
      MODE_SHR: shout_o = cur_i[0];
      default:  shout_o = shout_i;
    endcase
  end
endmodule

// File: rtl/shreg_state.sv
module shreg_state #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] nxt_i,
  input  logic             shout_i,
  output logic [WIDTH-1:0] q_o,
  output logic             shout_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o     <= '0;
      shout_o <= 1'b0;
    end else begin
      q_o     <= nxt_i;
      shout_o <= shout_i;
    end
  end
endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import shreg_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             cin_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o,
  output logic             shout_o
);
  localparam int unsigned MSB = WIDTH - 1;

  shreg_mode_e      mode;
  logic [WIDTH-1:0] nxt;
  logic             shout_nxt;

  assign mode = shreg_mode_e'(mode_i);

  shreg_next #(.WIDTH(WIDTH)) u_next (
    .mode_i  (mode),
    .cin_i   (cin_i),
    .cur_i   (q_o),
    .data_i  (data_i),
    .shout_i (shout_o),
    .nxt_o   (nxt),
    .shout_o (shout_nxt)
  );

  shreg_state #(.WIDTH(WIDTH)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nxt_i   (nxt),
    .shout_i (shout_nxt),
    .q_o     (q_o),
    .shout_o (shout_o)
  );

  AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |=> $stable(q_o)); // R2
  AST_SHL_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b01 |=> q_o == {$past(q_o[MSB-1:0]), $past(cin_i)}); // R3
  AST_SHR_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b10 |=> q_o == {$past(cin_i), $past(q_o[MSB:1])}); // R4
  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |=> q_o == $past(data_i)); // R5
  AST_SHL_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b01 |=> shout_o == $past(q_o[MSB])); // R6
  AST_SHR_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b10 |=> shout_o == $past(q_o[0])); // R6
  AST_OUT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 || mode_i == 2'b11) |=> $stable(shout_o)); // R7
endmodule

// File: tb/bidir_shift_reg_bench.sv
module bidir_shift_reg_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       cin_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [7:0] q_o;
  logic       shout_o;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_q = 8'h00;
  logic       exp_so = 1'b0;
  bit         done = 0;

  bidir_shift_reg u_bidir_shift_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .cin_i(cin_i),
    .data_i(data_i), .q_o(q_o), .shout_o(shout_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, logic [8:0] got, logic [8:0] expv);
    tests++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s got q=%h so=%b expected q=%h so=%b",
               req, got[8:1], got[0], expv[8:1], expv[0]);
    end
  endtask

  function automatic logic [8:0] model(logic [1:0] m, logic c, logic [7:0] d,
                                       logic [7:0] q, logic so);
    case (m)
      2'b01:   return {q[6:0], c, q[7]};
      2'b10:   return {c, q[7:1], q[0]};
      2'b11:   return {d, so};
      default: return {q, so};
    endcase
  endfunction

  function automatic string tag(logic [1:0] m);
    case (m)
      2'b00:   return "R2 hold";
      2'b01:   return "R3/R6 shift left";
      2'b10:   return "R4/R6 shift right";
      default: return "R5/R7 load";
    endcase
  endfunction

  task automatic step(logic [1:0] m, logic c, logic [7:0] d);
    logic [8:0] e;
    @(negedge clk_i);
    mode_i = m; cin_i = c; data_i = d;
    #1;
    if (m == 2'b11) check("R5 no change before edge", {q_o, shout_o}, {exp_q, exp_so});
    e = model(m, c, d, exp_q, exp_so);
    exp_q = e[8:1]; exp_so = e[0];
    @(posedge clk_i);
    #1;
    check(tag(m), {q_o, shout_o}, {exp_q, exp_so});
  endtask

  task automatic mid_clear();
    @(negedge clk_i);
    mode_i = 2'b11; data_i = 8'hA5;
    #2 rst_ni = 1'b0;
    #1 check("R1 async clear mid-cycle", {q_o, shout_o}, 9'h000);
    @(posedge clk_i); #1;
    check("R1 clear overrides load", {q_o, shout_o}, 9'h000);
    @(negedge clk_i);
    rst_ni = 1'b1; mode_i = 2'b00;
    exp_q = 8'h00; exp_so = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #1 check("R1 reset state", {q_o, shout_o}, 9'h000);
    @(posedge clk_i); #1;
    check("R1 held through edge", {q_o, shout_o}, 9'h000);
    @(negedge clk_i) rst_ni = 1'b1;

    // directed corners
    step(2'b11, 1'b0, 8'h09);
    step(2'b10, 1'b0, 8'h00);
    check("R4 0x09>>1 = 0x04, shout 1 (R6)", {q_o, shout_o}, {8'h04, 1'b1});
    step(2'b11, 1'b0, 8'h40);
    check("R7 load keeps shout", {1'b0, shout_o}, {1'b0, 1'b1});
    step(2'b01, 1'b0, 8'h00);
    check("R3 0x40<<1 = 0x80", {q_o, shout_o}, {8'h80, 1'b0});
    step(2'b00, 1'b1, 8'hFF);
    check("R2 hold", {q_o, shout_o}, {8'h80, 1'b0});
    step(2'b01, 1'b1, 8'h00);
    check("R8 left fill 1", {q_o, shout_o}, {8'h01, 1'b1});
    step(2'b10, 1'b1, 8'h00);
    check("R8 right fill 1", {q_o, shout_o}, {8'h80, 1'b1});
    step(2'b00, 1'b0, 8'h3C);
    check("R7 hold keeps shout", {q_o, shout_o}, {8'h80, 1'b1});
    mid_clear();

    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 39) == 0) mid_clear();
      else step(2'($urandom), 1'($urandom), 8'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule